// File: doc/BRIEF.md
# Memory-Mapped Performance Counter Unit

This block is a monitoring unit with eight counter slots behind a simple 64-bit register port. Each slot owns two 64-bit counters: a main counter and an extended counter. Both share one control word, so a single event can yield a paired measurement, such as accumulated delay cycles together with the number of packets, or bytes moved together with elapsed time. The event logic outside the block has already chosen what each slot counts. It presents per-slot increments, each with a valid strobe, for the main and the extended counter.

Software loads each slot's control word, preloads the counters (often to 2^63 so that wrap is far away), and sets a global run bit. It reads the counters while they run. When either counter of a slot wraps past all-ones, the slot raises a sticky status flag. The flag is cleared by writing 1 to it. Each slot has a mask bit that keeps its flag from reaching the single combined interrupt line. The qualification fields in the control word (threshold, trigger and target selection) are held and read back only. Three read-only words describe the monitored requester-ID range, a version, and the core and cluster location.

Top module: `pmon_unit`

## Requirements
- R1: After reset, every counter, every control word, the global run bit and every status flag read 0. Every mask bit reads 1, and `irqOut` is low.
- R2: Bit 0 of the register at 0x000 is the global run bit. While it is 0, no counter changes on increments, and all counter values are kept.
- R3: The control word of slot i is at 0x010+8*i. Bits 15:0 hold the event code and bit 20 is the slot enable. A counter adds its increment on a clock edge where its valid strobe is high, bit 20 is set and the global run bit is set. A write to the control word takes effect from the next cycle.
- R4: A control-word write with bit 22 set clears both counters of that slot on that edge. Bit 22 is not stored and always reads back 0.
- R5: All other control-word bits are stored and read back unchanged. This includes the threshold length 31:28, mode 27 and enable 26, the trigger length 59:56, mode 53 and enable 52, the target 51:36, the requester-ID flag 32 and the init bit 34.
- R6: The main counter of slot i is at 0x090+8*i and the extended counter is at 0x110+8*i. Both are fully writable and readable 64-bit registers. A register write wins over an increment in the same cycle.
- R7: A wrap of either counter of slot i sets bit 0 of the status register at 0x150+8*i on the same edge that updates the counter. Writing 1 to bit 0 clears it, and writing 0 leaves it alone. When a wrap and a clear arrive together, the flag stays set.
- R8: Bit 0 of the mask register at 0x154+8*i blocks slot i when it is 1. `irqOut` is high when at least one slot has its status set and its mask clear.
- R9: 0xFE0 reads {highest requester ID, lowest requester ID} in bits 31:16 and 15:0. 0xFE4 reads the version word. 0xFE8 reads {cluster number, core number} in bits 31:16 and 15:0. Writes to these three addresses have no effect, and any unmapped address reads 0.
- R10: The main and extended counters of a slot advance independently, each on its own strobe. An increment presented to one slot never changes another slot's counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe for the current address |
| regAddr | input | 12 | Byte address of the register access |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Read data for `regAddr`, available in the same cycle |
| mainInc | input | 128 | Main-counter increment, 16 bits per slot, slot i in bits 16*i+15:16*i |
| mainVld | input | 8 | Per-slot valid strobe for `mainInc` |
| extInc | input | 128 | Extended-counter increment, 16 bits per slot |
| extVld | input | 8 | Per-slot valid strobe for `extInc` |
| irqOut | output | 1 | Combined interrupt, OR of the unmasked set status flags |

## Verification
The assertions take for granted that a register write addresses only one register in a cycle. A write therefore never hits a counter and its slot's control word together, and the clear and write strobes of a slot are never both active. The bench issues every register access through a single-address write task. The one case where a register write and an increment meet in the same cycle combines a write with an event strobe and never two writes. The wrap checks assume that increments stay within their 16-bit field, which the bench's constants respect.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int NUM_SLOTS   = 8;
  localparam int CNT_W       = 64;
  localparam int DATA_W      = 64;
  localparam int ADDR_W      = 12;
  localparam int INC_W       = 16;
  localparam int SLOT_STRIDE = 8;

  localparam logic [ADDR_W-1:0] OFS_GLOBAL = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_MAIN   = 12'h090;
  localparam logic [ADDR_W-1:0] OFS_EXT    = 12'h110;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 12'h150;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h154;
  localparam logic [ADDR_W-1:0] OFS_RANGE  = 12'hFE0;
  localparam logic [ADDR_W-1:0] OFS_VER    = 12'hFE4;
  localparam logic [ADDR_W-1:0] OFS_LOC    = 12'hFE8;

  localparam int BIT_SLOT_EN = 20;
  localparam int BIT_CLR     = 22;

  // strobes from the control side to the counter datapath
  typedef struct packed {
    logic [NUM_SLOTS-1:0] mainWr;
    logic [NUM_SLOTS-1:0] extWr;
    logic [NUM_SLOTS-1:0] clr;
    logic [NUM_SLOTS-1:0] run;
    logic [DATA_W-1:0]    wrData;
  } dp_cmd_t;
endpackage

// File: rtl/pmon_counter.sv
module pmon_counter #(
  parameter int W  = 64,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [W-1:0]  wrData,
  input  logic          clr,
  input  logic          incEn,
  input  logic [IW-1:0] incVal,
  output logic [W-1:0]  cnt,
  output logic          wrap
);
  logic [W:0] sum;

  assign sum  = {1'b0, cnt} + {{(W+1-IW){1'b0}}, incVal};
  // a write or clear replaces the increment, so only a real add can wrap
  assign wrap = incEn && !wrEn && !clr && sum[W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (wrEn)  cnt <= wrData;
    else if (clr)   cnt <= '0;
    else if (incEn) cnt <= sum[W-1:0];
  end
endmodule

// File: rtl/pmon_datapath.sv
module pmon_datapath
  import pmon_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  dp_cmd_t                    cmd,
  input  logic [NUM_SLOTS*INC_W-1:0] mainInc,
  input  logic [NUM_SLOTS-1:0]       mainVld,
  input  logic [NUM_SLOTS*INC_W-1:0] extInc,
  input  logic [NUM_SLOTS-1:0]       extVld,
  output logic [CNT_W-1:0]           mainCnt [NUM_SLOTS],
  output logic [CNT_W-1:0]           extCnt  [NUM_SLOTS],
  output logic [NUM_SLOTS-1:0]       wrapVec
);
  logic [NUM_SLOTS-1:0] mainWrap;
  logic [NUM_SLOTS-1:0] extWrap;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    pmon_counter #(.W(CNT_W), .IW(INC_W)) u_main (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (cmd.mainWr[g]),
      .wrData (cmd.wrData),
      .clr    (cmd.clr[g]),
      .incEn  (cmd.run[g] && mainVld[g]),
      .incVal (mainInc[g*INC_W +: INC_W]),
      .cnt    (mainCnt[g]),
      .wrap   (mainWrap[g])
    );
    pmon_counter #(.W(CNT_W), .IW(INC_W)) u_ext (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (cmd.extWr[g]),
      .wrData (cmd.wrData),
      .clr    (cmd.clr[g]),
      .incEn  (cmd.run[g] && extVld[g]),
      .incVal (extInc[g*INC_W +: INC_W]),
      .cnt    (extCnt[g]),
      .wrap   (extWrap[g])
    );
  end

  assign wrapVec = mainWrap | extWrap;
endmodule

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
  import pmon_pkg::*;
#(
  parameter logic [15:0] MIN_RID    = 16'h0000,
  parameter logic [15:0] MAX_RID    = 16'h00FF,
  parameter logic [31:0] VERSION    = 32'h0000_0001,
  parameter logic [15:0] CORE_ID    = 16'h0000,
  parameter logic [15:0] CLUSTER_ID = 16'h0000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  output logic [DATA_W-1:0]    regRdData,
  input  logic [CNT_W-1:0]     mainCnt [NUM_SLOTS],
  input  logic [CNT_W-1:0]     extCnt  [NUM_SLOTS],
  input  logic [NUM_SLOTS-1:0] wrapVec,
  output dp_cmd_t              cmd,
  output logic [NUM_SLOTS-1:0] statusVec,
  output logic [NUM_SLOTS-1:0] maskVec
);
  localparam logic [DATA_W-1:0] KEEP_MASK = ~(DATA_W'(1) << BIT_CLR);

  logic                 globalEn;
  logic [DATA_W-1:0]    ctrlWord [NUM_SLOTS];
  logic                 hitGlobal;
  logic [NUM_SLOTS-1:0] hitCtrl, hitMain, hitExt, hitStat, hitMask;

  assign hitGlobal = (regAddr == OFS_GLOBAL);

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      hitCtrl[i] = (regAddr == OFS_CTRL + ADDR_W'(SLOT_STRIDE * i));
      hitMain[i] = (regAddr == OFS_MAIN + ADDR_W'(SLOT_STRIDE * i));
      hitExt[i]  = (regAddr == OFS_EXT  + ADDR_W'(SLOT_STRIDE * i));
      hitStat[i] = (regAddr == OFS_STAT + ADDR_W'(SLOT_STRIDE * i));
      hitMask[i] = (regAddr == OFS_MASK + ADDR_W'(SLOT_STRIDE * i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalEn  <= 1'b0;
      statusVec <= '0;
      maskVec   <= '1;
      for (int i = 0; i < NUM_SLOTS; i++) ctrlWord[i] <= '0;
    end else begin
      if (regWrEn && hitGlobal) globalEn <= regWrData[0];
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (regWrEn && hitCtrl[i]) ctrlWord[i] <= regWrData & KEEP_MASK;
        if (regWrEn && hitMask[i]) maskVec[i] <= regWrData[0];
        // a new wrap outranks a same-cycle clear
        statusVec[i] <= wrapVec[i] |
                        (statusVec[i] & ~(regWrEn & hitStat[i] & regWrData[0]));
      end
    end
  end

  always_comb begin
    cmd.wrData = regWrData;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      cmd.mainWr[i] = regWrEn && hitMain[i];
      cmd.extWr[i]  = regWrEn && hitExt[i];
      cmd.clr[i]    = regWrEn && hitCtrl[i] && regWrData[BIT_CLR];
      cmd.run[i]    = globalEn && ctrlWord[i][BIT_SLOT_EN];
    end
  end

  always_comb begin
    regRdData = '0;
    if (hitGlobal)             regRdData[0]    = globalEn;
    if (regAddr == OFS_RANGE)  regRdData[31:0] = {MAX_RID, MIN_RID};
    if (regAddr == OFS_VER)    regRdData[31:0] = VERSION;
    if (regAddr == OFS_LOC)    regRdData[31:0] = {CLUSTER_ID, CORE_ID};
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (hitCtrl[i]) regRdData    = ctrlWord[i];
      if (hitMain[i]) regRdData    = mainCnt[i];
      if (hitExt[i])  regRdData    = extCnt[i];
      if (hitStat[i]) regRdData[0] = statusVec[i];
      if (hitMask[i]) regRdData[0] = maskVec[i];
    end
  end
endmodule

// File: rtl/pmon_unit.sv
module pmon_unit
  import pmon_pkg::*;
#(
  parameter logic [15:0] MIN_RID    = 16'h0000,
  parameter logic [15:0] MAX_RID    = 16'h00FF,
  parameter logic [31:0] VERSION    = 32'h0000_0001,
  parameter logic [15:0] CORE_ID    = 16'h0000,
  parameter logic [15:0] CLUSTER_ID = 16'h0000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWrEn,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic [DATA_W-1:0]          regWrData,
  output logic [DATA_W-1:0]          regRdData,
  input  logic [NUM_SLOTS*INC_W-1:0] mainInc,
  input  logic [NUM_SLOTS-1:0]       mainVld,
  input  logic [NUM_SLOTS*INC_W-1:0] extInc,
  input  logic [NUM_SLOTS-1:0]       extVld,
  output logic                       irqOut
);
  dp_cmd_t              cmd;
  logic [CNT_W-1:0]     mainCnt [NUM_SLOTS];
  logic [CNT_W-1:0]     extCnt  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] wrapVec;
  logic [NUM_SLOTS-1:0] statusVec;
  logic [NUM_SLOTS-1:0] maskVec;

  pmon_ctrl #(
    .MIN_RID(MIN_RID), .MAX_RID(MAX_RID), .VERSION(VERSION),
    .CORE_ID(CORE_ID), .CLUSTER_ID(CLUSTER_ID)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .mainCnt   (mainCnt),
    .extCnt    (extCnt),
    .wrapVec   (wrapVec),
    .cmd       (cmd),
    .statusVec (statusVec),
    .maskVec   (maskVec)
  );

  pmon_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .mainInc (mainInc),
    .mainVld (mainVld),
    .extInc  (extInc),
    .extVld  (extVld),
    .mainCnt (mainCnt),
    .extCnt  (extCnt),
    .wrapVec (wrapVec)
  );

  assign irqOut = |(statusVec & ~maskVec);
endmodule

// File: rtl/pmon_unit_chk.sv
module pmon_unit_chk
  import pmon_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input dp_cmd_t              cmd,
  input logic [CNT_W-1:0]     mainCnt [NUM_SLOTS],
  input logic [CNT_W-1:0]     extCnt  [NUM_SLOTS],
  input logic [NUM_SLOTS-1:0] wrapVec,
  input logic [NUM_SLOTS-1:0] statusVec
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
      wrapVec[g] |=> statusVec[g]); // R7
    AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusVec[g]) |-> $past(wrapVec[g])); // R7
    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
      cmd.clr[g] |=> (mainCnt[g] == '0 && extCnt[g] == '0)); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
      cmd.mainWr[g] |=> mainCnt[g] == $past(cmd.wrData)); // R6
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (!cmd.run[g] && !cmd.mainWr[g] && !cmd.extWr[g] && !cmd.clr[g])
        |=> ($stable(mainCnt[g]) && $stable(extCnt[g]))); // R2
  end
endmodule

bind pmon_unit pmon_unit_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cmd       (cmd),
  .mainCnt   (mainCnt),
  .extCnt    (extCnt),
  .wrapVec   (wrapVec),
  .statusVec (statusVec)
);

// File: tb/pmon_unit_bench.sv
module pmon_unit_bench;
  import pmon_pkg::*;

  localparam logic [15:0] B_MIN = 16'h0100;
  localparam logic [15:0] B_MAX = 16'h01FF;
  localparam logic [31:0] B_VER = 32'h0000_0031;
  localparam logic [15:0] B_CORE = 16'h0002;
  localparam logic [15:0] B_CLUS = 16'h0005;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic [NUM_SLOTS*INC_W-1:0] mainInc = '0, extInc = '0;
  logic [NUM_SLOTS-1:0] mainVld = '0, extVld = '0;
  logic irqOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pmon_unit #(.MIN_RID(B_MIN), .MAX_RID(B_MAX), .VERSION(B_VER),
              .CORE_ID(B_CORE), .CLUSTER_ID(B_CLUS)) u_pmon_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .mainInc(mainInc),
    .mainVld(mainVld), .extInc(extInc), .extVld(extVld), .irqOut(irqOut));

  function automatic logic [ADDR_W-1:0] aCtrl(int s); return ADDR_W'(12'h010 + 8*s); endfunction
  function automatic logic [ADDR_W-1:0] aMain(int s); return ADDR_W'(12'h090 + 8*s); endfunction
  function automatic logic [ADDR_W-1:0] aExt(int s);  return ADDR_W'(12'h110 + 8*s); endfunction
  function automatic logic [ADDR_W-1:0] aStat(int s); return ADDR_W'(12'h150 + 8*s); endfunction
  function automatic logic [ADDR_W-1:0] aMask(int s); return ADDR_W'(12'h154 + 8*s); endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [63:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(string req, logic [ADDR_W-1:0] a, logic [63:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 chk(req, regRdData, exp);
  endtask

  task automatic pulse(int s, logic [15:0] mv, bit mOn, logic [15:0] ev, bit eOn, int n);
    @(negedge clk);
    mainInc[s*INC_W +: INC_W] = mv; mainVld[s] = mOn;
    extInc[s*INC_W +: INC_W] = ev;  extVld[s] = eOn;
    repeat (n) @(negedge clk);
    mainVld[s] = 1'b0; extVld[s] = 1'b0;
  endtask

  task automatic t_reset();
    rdChk("R1 global", 12'h000, 64'd0);
    rdChk("R1 ctrl0", aCtrl(0), 64'd0);
    rdChk("R1 main3", aMain(3), 64'd0);
    rdChk("R1 ext7", aExt(7), 64'd0);
    rdChk("R1 mask5", aMask(5), 64'd1);
    rdChk("R1 stat0", aStat(0), 64'd0);
    chk("R1 irq", 64'(irqOut), 64'd0);
  endtask

  task automatic t_count();
    wr(12'h000, 64'd1);
    wr(aCtrl(1), 64'h0000_0000_0010_0010);
    pulse(1, 16'd5, 1'b1, 16'd1, 1'b1, 4);
    pulse(2, 16'd9, 1'b1, 16'd9, 1'b1, 3);   // slot 2 not enabled
    rdChk("R3 main1", aMain(1), 64'd20);
    rdChk("R3 ext1", aExt(1), 64'd4);
    rdChk("R3 main2 disabled", aMain(2), 64'd0);
    rdChk("R10 other slot untouched", aMain(0), 64'd0);
    wr(aCtrl(6), 64'h0000_0000_0010_0001);
    pulse(6, 16'd7, 1'b1, 16'd0, 1'b0, 2);
    rdChk("R10 main6 alone", aMain(6), 64'd14);
    rdChk("R10 ext6 idle", aExt(6), 64'd0);
  endtask

  task automatic t_halt();
    wr(12'h000, 64'd0);
    rdChk("R2 global readback", 12'h000, 64'd0);
    pulse(1, 16'd5, 1'b1, 16'd1, 1'b1, 3);
    rdChk("R2 main1 held", aMain(1), 64'd20);
    rdChk("R2 ext1 held", aExt(1), 64'd4);
    wr(12'h000, 64'd1);
  endtask

  task automatic t_fields();
    wr(aCtrl(3), 64'h0A20_ABCD_5C0A_1234);
    rdChk("R5 fields kept", aCtrl(3), 64'h0A20_ABCD_5C0A_1234);
    wr(aCtrl(3), 64'h0000_0004_0050_0010);
    rdChk("R4 pulse bit not stored", aCtrl(3), 64'h0000_0004_0010_0010);
  endtask

  task automatic t_clear();
    wr(aCtrl(1), 64'h0000_0000_0050_0010);
    rdChk("R4 main1 cleared", aMain(1), 64'd0);
    rdChk("R4 ext1 cleared", aExt(1), 64'd0);
  endtask

  task automatic t_wrap();
    wr(aCtrl(4), 64'h0000_0000_0010_0000);
    wr(aMask(4), 64'd0);
    wr(aMain(4), 64'hFFFF_FFFF_FFFF_FFFE);
    pulse(4, 16'd3, 1'b1, 16'd0, 1'b0, 1);
    rdChk("R7 main wrapped value", aMain(4), 64'd1);
    rdChk("R7 status set", aStat(4), 64'd1);
    chk("R8 irq unmasked", 64'(irqOut), 64'd1);
    wr(aMask(4), 64'd1);
    chk("R8 irq masked", 64'(irqOut), 64'd0);
    rdChk("R8 status kept under mask", aStat(4), 64'd1);
    wr(aMask(4), 64'd0);
    wr(aStat(4), 64'd0);
    rdChk("R7 write 0 keeps", aStat(4), 64'd1);
    wr(aStat(4), 64'd1);
    rdChk("R7 w1c", aStat(4), 64'd0);
    chk("R8 irq after clear", 64'(irqOut), 64'd0);
    wr(aExt(4), 64'hFFFF_FFFF_FFFF_FFFF);
    pulse(4, 16'd0, 1'b0, 16'd1, 1'b1, 1);
    rdChk("R7 ext wrap flags", aStat(4), 64'd1);
    // wrap and clear in the same cycle
    wr(aMain(4), 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = aStat(4); regWrData = 64'd1;
    mainInc[4*INC_W +: INC_W] = 16'd1; mainVld[4] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; mainVld[4] = 1'b0;
    rdChk("R7 set wins over clear", aStat(4), 64'd1);
  endtask

  task automatic t_priority();
    wr(aCtrl(5), 64'h0000_0000_0010_0000);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = aMain(5); regWrData = 64'd100;
    mainInc[5*INC_W +: INC_W] = 16'd7; mainVld[5] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; mainVld[5] = 1'b0;
    rdChk("R6 write beats increment", aMain(5), 64'd100);
    wr(aExt(5), 64'h8000_0000_0000_0000);
    rdChk("R6 ext full width", aExt(5), 64'h8000_0000_0000_0000);
    wr(aMain(7), 64'hDEAD_BEEF_0123_4567);
    rdChk("R6 main full width", aMain(7), 64'hDEAD_BEEF_0123_4567);
  endtask

  task automatic t_id();
    rdChk("R9 range", 12'hFE0, {32'd0, B_MAX, B_MIN});
    rdChk("R9 version", 12'hFE4, {32'd0, B_VER});
    rdChk("R9 location", 12'hFE8, {32'd0, B_CLUS, B_CORE});
    wr(12'hFE0, 64'hFFFF_FFFF_FFFF_FFFF);
    rdChk("R9 range ignores write", 12'hFE0, {32'd0, B_MAX, B_MIN});
    wr(12'h800, 64'h1234);
    rdChk("R9 unmapped", 12'h800, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_count();
    t_halt();
    t_fields();
    t_clear();
    t_wrap();
    t_priority();
    t_id();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule